// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block drives the active-low hardware reset line of a parallel flash device and keeps the rest of the system off the flash bus until the device is usable again. A one-cycle (or longer) request starts a sequence. The reset line is held low for a minimum pulse width. It is then released, and access stays blocked until two conditions hold. First, a recovery window, counted from the falling edge of reset, has run out. Second, reset has been high for a minimum settle time. When the sequence ends, the device is back in normal array-read mode and the ready output rises again.

The recovery window has two lengths. A short one applies when the device was idle. A long one applies when the device was busy with an internal program or erase. The busy input is sampled once, on the clock edge that accepts the request. All time limits are given in nanoseconds and turned into cycle counts, rounded up, from a clock-period parameter.

The sequencer has three states. `ST_IDLE` drives reset high and ready high. `ST_PULSE` drives reset low and ready low. `ST_RECOVER` drives reset high and ready low. Transition T_START (`ST_IDLE` to `ST_PULSE`) happens on a request. Transition T_RELEASE (`ST_PULSE` to `ST_RECOVER`) happens when the pulse count is reached. Transition T_READY (`ST_RECOVER` to `ST_IDLE`) happens when the selected window has elapsed.

Top module: `flash_rst_seq`

## Requirements
- R1: After system reset, `flash_rst_n` is 1 and `access_ok` is 1. No sequence is running.
- R2: A request sampled high in the idle state drives `flash_rst_n` low from the next cycle, for exactly P = ceil(PULSE_NS/CLK_NS) cycles (50 with the defaults).
- R3: The window length is chosen by `dev_busy` as sampled on the same edge that accepts the request (1 selects the long window). Later changes of `dev_busy` do not alter the running sequence.
- R4: With `dev_busy` = 0 at the request, `access_ok` stays low for exactly max(ceil(IDLE_WAIT_NS/CLK_NS), P+H) cycles (55 with the defaults).
- R5: With `dev_busy` = 1 at the request, `access_ok` stays low for exactly max(ceil(BUSY_WAIT_NS/CLK_NS), P+H) cycles (2000 with the defaults).
- R6: `flash_rst_n` is high for at least H = ceil(HIGH_NS/CLK_NS) cycles (5 with the defaults) before `access_ok` rises.
- R7: `access_ok` is low whenever `flash_rst_n` is low. A request arriving while a sequence runs, including in its final cycle, causes no second pulse and does not lengthen the sequence.
- R8: A request that is still high in the first idle cycle after a sequence starts a new sequence, so `access_ok` is high for exactly one cycle between the two.
- R9: Without a request, both outputs stay high whatever `dev_busy` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period in ns is the CLK_NS parameter |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req | input | 1 | Request to reset the flash device |
| dev_busy | input | 1 | High while the device runs an internal program or erase |
| flash_rst_n | output | 1 | Active-low reset line to the flash device |
| access_ok | output | 1 | High when the flash bus may be used |

## Verification
Two functions can fall in the same cycle. The first is a fresh request arriving in the cycle where T_READY fires. The second is a new request at the same point where a held request is accepted again. The bench provokes the first by pulsing the request on the last blocked cycle, and judges it by a single pulse and an unchanged 55-cycle blocked span. It provokes the second by holding the request across the end of a sequence, and judges it by exactly one ready cycle between two pulses. It also flips the busy input on the cycle right after the request, to show that only the sample at acceptance chooses the window.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_t;

    // Round a time in ns up to whole clock cycles.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_rst_timer.sv
// Elapsed-cycle counter, loaded with 1 on the accepting edge, saturating.
module flash_rst_timer #(
    parameter int CW        = 11,
    parameter int PULSE_CYC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          pulse_end
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] P_LIM   = CW'(PULSE_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (run && (cnt != CNT_MAX)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign pulse_end = (cnt == P_LIM);
endmodule

// File: rtl/flash_rst_mode.sv
// Latches the busy sample at acceptance and compares against the chosen window.
module flash_rst_mode #(
    parameter int CW        = 11,
    parameter int SHORT_CYC = 55,
    parameter int LONG_CYC  = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dev_busy,
    input  logic [CW-1:0] cnt,
    output logic          wait_end
);
    localparam logic [CW-1:0] S_LIM = CW'(SHORT_CYC);
    localparam logic [CW-1:0] L_LIM = CW'(LONG_CYC);

    logic long_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            long_sel <= 1'b0;
        end else if (start) begin
            long_sel <= dev_busy;
        end
    end

    always_comb begin
        wait_end = (cnt >= (long_sel ? L_LIM : S_LIM));
    end
endmodule

// File: rtl/flash_rst_fsm.sv
module flash_rst_fsm
    import flash_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pulse_end,
    input  logic wait_end,
    output logic start,
    output logic run,
    output logic flash_rst_n,
    output logic access_ok
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req)       state_nx = ST_PULSE;    // T_START
            ST_PULSE:   if (pulse_end) state_nx = ST_RECOVER;  // T_RELEASE
            ST_RECOVER: if (wait_end)  state_nx = ST_IDLE;     // T_READY
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start       = 1'b0;
        run         = 1'b0;
        flash_rst_n = 1'b1;
        access_ok   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                access_ok = 1'b1;
                start     = req;
            end
            ST_PULSE: begin
                flash_rst_n = 1'b0;
                run         = 1'b1;
            end
            ST_RECOVER: begin
                run = 1'b1;
            end
            default: begin
                access_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import flash_rst_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int PULSE_NS     = 500,
    parameter int IDLE_WAIT_NS = 500,
    parameter int BUSY_WAIT_NS = 20000,
    parameter int HIGH_NS      = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic dev_busy,
    output logic flash_rst_n,
    output logic access_ok
);
    localparam int PULSE_CYC = max_int(1, ns_to_cycles(PULSE_NS, CLK_NS));
    localparam int HIGH_CYC  = max_int(1, ns_to_cycles(HIGH_NS, CLK_NS));
    localparam int SHORT_CYC = max_int(ns_to_cycles(IDLE_WAIT_NS, CLK_NS), PULSE_CYC + HIGH_CYC);
    localparam int LONG_CYC  = max_int(ns_to_cycles(BUSY_WAIT_NS, CLK_NS), PULSE_CYC + HIGH_CYC);
    localparam int CW        = $clog2(max_int(SHORT_CYC, LONG_CYC) + 2);

    logic          start, run, pulse_end, wait_end;
    logic [CW-1:0] cnt;

    flash_rst_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req),
        .pulse_end(pulse_end), .wait_end(wait_end),
        .start(start), .run(run),
        .flash_rst_n(flash_rst_n), .access_ok(access_ok)
    );

    flash_rst_timer #(.CW(CW), .PULSE_CYC(PULSE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run),
        .cnt(cnt), .pulse_end(pulse_end)
    );

    flash_rst_mode #(.CW(CW), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_mode (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_busy(dev_busy),
        .cnt(cnt), .wait_end(wait_end)
    );
endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk
    import flash_rst_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int PULSE_NS     = 500,
    parameter int IDLE_WAIT_NS = 500,
    parameter int BUSY_WAIT_NS = 20000,
    parameter int HIGH_NS      = 50
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic dev_busy,
    input logic flash_rst_n,
    input logic access_ok
);
    localparam int P_C = max_int(1, ns_to_cycles(PULSE_NS, CLK_NS));
    localparam int H_C = max_int(1, ns_to_cycles(HIGH_NS, CLK_NS));
    localparam int S_C = max_int(ns_to_cycles(IDLE_WAIT_NS, CLK_NS), P_C + H_C);
    localparam int L_C = max_int(ns_to_cycles(BUSY_WAIT_NS, CLK_NS), P_C + H_C);

    int   low_cnt, hi_cnt, blk_cnt;
    logic mode_long;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= 0;
            hi_cnt    <= 0;
            blk_cnt   <= 0;
            mode_long <= 1'b0;
        end else begin
            low_cnt <= flash_rst_n ? 0 : low_cnt + 1;
            hi_cnt  <= access_ok ? 0 : (flash_rst_n ? hi_cnt + 1 : 0);
            blk_cnt <= access_ok ? 0 : blk_cnt + 1;
            if (access_ok && req) mode_long <= dev_busy;
        end
    end

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_n) |-> (low_cnt == P_C));

    // R6
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> (hi_cnt >= H_C));

    // R4 R5 R3
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> (blk_cnt == (mode_long ? L_C : S_C)));

    // R7
    blocked_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |-> !access_ok);

    // R7
    fall_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_rst_n) |-> $past(access_ok));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && !req) |=> (access_ok && flash_rst_n));
endmodule

bind flash_rst_seq flash_rst_seq_chk #(
    .CLK_NS(CLK_NS), .PULSE_NS(PULSE_NS), .IDLE_WAIT_NS(IDLE_WAIT_NS),
    .BUSY_WAIT_NS(BUSY_WAIT_NS), .HIGH_NS(HIGH_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_busy(dev_busy),
    .flash_rst_n(flash_rst_n), .access_ok(access_ok)
);

// File: tb/sim_flash_rst_seq.sv
`timescale 1ns/1ps
module sim_flash_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P_EXP  = (500 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int H_EXP  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int SI     = (500 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int LI     = (20000 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int S_EXP  = (SI > P_EXP + H_EXP) ? SI : P_EXP + H_EXP;
    localparam int L_EXP  = (LI > P_EXP + H_EXP) ? LI : P_EXP + H_EXP;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, dev_busy = 1'b0;
    logic flash_rst_n, access_ok;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    flash_rst_seq #(.CLK_NS(CLK_PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .dev_busy(dev_busy),
        .flash_rst_n(flash_rst_n), .access_ok(access_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: time since reset fell, and the chosen window.
    bit m_act = 0, m_long = 0;
    int m_t = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_t = 0;
        end else if (!m_act) begin
            if (req) begin m_act = 1; m_t = 1; m_long = dev_busy; end
        end else if (m_t >= (m_long ? L_EXP : S_EXP)) begin
            m_act = 0;
        end else begin
            m_t++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Measurements and per-cycle comparison, sampled at the falling edge.
    int low_run = 0, last_low = 0, n_pulses = 0;
    int blk_run = 0, hi_run = 0, last_blk = 0, last_hi = 0;
    int ok_run = 0, last_ok = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(flash_rst_n == !(m_act && m_t <= P_EXP), "R2 reset line",
                  int'(flash_rst_n), int'(!(m_act && m_t <= P_EXP)));
            check(access_ok == !m_act, "R4/R5 ready", int'(access_ok), int'(!m_act));
            if (!flash_rst_n) low_run++;
            else if (low_run != 0) begin last_low = low_run; low_run = 0; n_pulses++; end
            if (!access_ok) begin
                blk_run++;
                if (flash_rst_n) hi_run++;
                if (ok_run != 0) begin last_ok = ok_run; ok_run = 0; end
            end else begin
                ok_run++;
                if (blk_run != 0) begin last_blk = blk_run; last_hi = hi_run; blk_run = 0; hi_run = 0; end
            end
        end
    end

    task automatic tick(input bit r, input bit b);
        @(negedge clk); #1;
        req = r; dev_busy = b;
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_up();
        end
    end

    initial begin
        int np;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(flash_rst_n === 1'b1, "R1 reset line", int'(flash_rst_n), 1);
        check(access_ok === 1'b1, "R1 ready", int'(access_ok), 1);

        // R9: busy toggling without a request
        for (int i = 0; i < 20; i++) tick(1'b0, i[0]);
        tick(1'b0, 1'b0);
        check(n_pulses == 0, "R9 no pulse", n_pulses, 0);
        check(access_ok === 1'b1, "R9 ready", int'(access_ok), 1);

        // R2 R4 R6: idle-path sequence
        tick(1'b1, 1'b0);
        for (int i = 0; i < S_EXP + 10; i++) tick(1'b0, 1'b0);
        check(last_low == P_EXP, "R2 pulse width", last_low, P_EXP);
        check(last_blk == S_EXP, "R4 short window", last_blk, S_EXP);
        check(last_hi >= H_EXP, "R6 settle time", last_hi, H_EXP);

        // R3 R5: busy at request, drops right after
        tick(1'b1, 1'b1);
        for (int i = 0; i < L_EXP + 10; i++) tick(1'b0, 1'b0);
        check(last_blk == L_EXP, "R5 long window", last_blk, L_EXP);
        check(last_low == P_EXP, "R2 pulse width busy", last_low, P_EXP);

        // R3: idle at request, busy rises right after
        tick(1'b1, 1'b0);
        for (int i = 0; i < S_EXP + 10; i++) tick(1'b0, 1'b1);
        check(last_blk == S_EXP, "R3 sample at accept", last_blk, S_EXP);
        tick(1'b0, 1'b0);

        // R7: requests mid pulse, mid recovery and in the last blocked cycle
        np = n_pulses;
        tick(1'b1, 1'b0);
        for (int k = 1; k <= S_EXP + 10; k++)
            tick((k == 10) || (k == S_EXP - 3) || (k == S_EXP), 1'b0);
        check(n_pulses == np + 1, "R7 single pulse", n_pulses, np + 1);
        check(last_blk == S_EXP, "R7 not extended", last_blk, S_EXP);
        check(access_ok === 1'b1, "R7 ready after", int'(access_ok), 1);

        // R8: request held across the end of a sequence
        np = n_pulses;
        for (int k = 0; k <= S_EXP + 1; k++) tick(1'b1, 1'b0);
        for (int k = 0; k < S_EXP + 10; k++) tick(1'b0, 1'b0);
        check(n_pulses == np + 2, "R8 two pulses", n_pulses, np + 2);
        check(last_ok == 1, "R8 one ready cycle", last_ok, 1);
        check(last_blk == S_EXP, "R8 second window", last_blk, S_EXP);

        repeat (5) tick(1'b0, 1'b1);
        finish_up();
    end
endmodule